// File: doc/BRIEF.md
# Page-Mode Nonvolatile RAM Controller

This block sits between a synchronous host and an asynchronous, SRAM-style nonvolatile memory of 512K words of 16 bits. The host hands it one word request at a time over a valid/ready channel: a word address, a write flag, write data and a two-bit byte mask. The controller drives the memory's two chip enables, write enable, output enable, byte strobes, address bus and write data. It captures read data and returns it to the host with a one-cycle valid pulse.

The memory latches the row part of the address when the chip is enabled. The controller therefore keeps the chip enabled while successive requests stay inside the same four-word page, and it changes only the two column bits between them. A request to a different row, a supply-low indication or an idle timeout closes the page. Every closed period lasts at least the precharge time. All timing minimums are given in nanoseconds and turned into clock counts, rounded up, from the clock period parameter.

Back-pressure rules: a request transfers on a clock edge where `req_valid` and `req_ready` are both high. The host must hold a request stable until it transfers. `req_ready` may be low for many cycles: during an access, during precharge, while a page is being closed and while supply is low. Responses cannot be stalled. Each read produces exactly one `rsp_valid` pulse, and responses come back in request order.

Top module: `nvram_page_ctrl`

## Requirements
- R1: Out of reset the chip is disabled (`mem_ce1_n`=1, `mem_ce2`=0), `mem_we_n`, `mem_oe_n`, `mem_ub_n` and `mem_lb_n` are 1, `mem_dq_oe` and `rsp_valid` are 0, and `req_ready` is 1.
- R2: A write stores the bytes whose mask bit is set (bit 0 = DQ[7:0] via `mem_lb_n`, bit 1 = DQ[15:8] via `mem_ub_n`) and leaves the other byte unchanged. Write enable is low only while the chip is enabled and output enable is high.
- R3: A read returns the stored word on `rsp_rdata` with a single-cycle `rsp_valid`, in request order. Bytes whose mask bit is clear read as zero.
- R4: The address, strobes and read/write enables are held for at least the access count (60 ns) before read data is captured or write enable rises on the first access after the chip is enabled.
- R5: While the chip stays enabled, `mem_addr[18:2]` does not change. A request to the open page is served without disabling the chip, in any column order.
- R6: A request whose `req_addr[18:2]` differs from the open page disables the chip, and the chip stays disabled for at least the precharge count (50 ns) before the next enable.
- R7: Each enabled period lasts at least the row-cycle count (115 ns).
- R8: An open page with no request for `IDLE_CYCLES` cycles is closed.
- R9: While `supply_low` is 1, `req_ready` is 0, no enable is started, and an open page is closed.
- R10: A request held while `req_ready` is low is not lost; it transfers once ready returns, and only one transfer happens per handshake.
- R11: Read latency from transfer to `rsp_valid` is exactly the access count (ceil(60 ns / period)) for a first access and the page count (ceil(30 ns / period)) within an open page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| supply_low | input | 1 | Supply below safe level; blocks access |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller accepts request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte mask, bit 1 = upper byte |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 16 | Read data, masked bytes zero |
| mem_ce1_n | output | 1 | Active-low chip enable |
| mem_ce2 | output | 1 | Active-high chip enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_ub_n | output | 1 | Active-low upper byte strobe |
| mem_lb_n | output | 1 | Active-low lower byte strobe |
| mem_addr | output | 19 | Memory word address |
| mem_dq_o | output | 16 | Data driven to memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | 16 | Data returned by memory |

## Verification
The bench attaches a memory model that hands out valid data only after the address has been stable for the required number of cycles. Because of that, a controller that samples too early returns wrong data instead of silently passing. Directed sequences first force a closed page and then stay inside one page. The latency measured in each case separates first-access timing from page timing. Further sequences walk the four columns out of order, jump between rows, hold requests through a supply-low window, and write with partial masks. Random traffic over a few rows with random gaps mixes page hits, misses and idle closures, and the model checks the precharge and row-cycle lengths on every enable.

// File: rtl/nvpc_pkg.sv
package nvpc_pkg;
  typedef enum logic [1:0] {PH_CLOSED, PH_ACCESS, PH_OPEN} phase_e;

  // Round a nanosecond minimum up to whole clock periods.
  function automatic int unsigned ns_to_cycles(input int unsigned ns, input int unsigned period_ps);
    return (ns * 1000 + period_ps - 1) / period_ps;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/nvpc_timer.sv
module nvpc_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  // True in the last cycle of the window: the next edge completes it.
  assign done = (cnt_q <= W'(1));
endmodule

// File: rtl/nvpc_page_track.sv
module nvpc_page_track #(
  parameter int ROW_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_en,
  input  logic             close_en,
  input  logic [ROW_W-1:0] row_in,
  output logic             hit
);
  logic             open_q;
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      row_q  <= '0;
    end else if (open_en) begin
      open_q <= 1'b1;
      row_q  <= row_in;
    end else if (close_en) begin
      open_q <= 1'b0;
    end
  end

  assign hit = open_q && (row_q == row_in);
endmodule

// File: rtl/nvram_page_ctrl.sv
module nvram_page_ctrl
  import nvpc_pkg::*;
#(
  parameter int ADDR_W         = 19,
  parameter int DATA_W         = 16,
  parameter int COL_W          = 2,
  parameter int CLK_PERIOD_PS  = 4000,
  parameter int T_ACCESS_NS    = 60,
  parameter int T_CYCLE_NS     = 115,
  parameter int T_PRECHARGE_NS = 50,
  parameter int T_PAGE_NS      = 30,
  parameter int IDLE_CYCLES    = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              supply_low,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_be,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_ce1_n,
  output logic              mem_ce2,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              mem_ub_n,
  output logic              mem_lb_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);
  localparam int unsigned ACC_CYC  = ns_to_cycles(T_ACCESS_NS, CLK_PERIOD_PS);
  localparam int unsigned CYC_CYC  = ns_to_cycles(T_CYCLE_NS, CLK_PERIOD_PS);
  localparam int unsigned PRE_CYC  = ns_to_cycles(T_PRECHARGE_NS, CLK_PERIOD_PS);
  localparam int unsigned PAGE_CYC = ns_to_cycles(T_PAGE_NS, CLK_PERIOD_PS);
  localparam int unsigned MAX_CYC  = umax(umax(ACC_CYC, CYC_CYC),
                                          umax(umax(PRE_CYC, PAGE_CYC), IDLE_CYCLES));
  localparam int CNT_W = $clog2(MAX_CYC + 2);
  localparam int ROW_W = ADDR_W - COL_W;
  localparam int LANES = DATA_W / 8;

  phase_e            ph_q;
  logic              ce_q, we_n_q, oe_n_q, dq_oe_q, rd_q, rsp_v_q;
  logic [LANES-1:0]  strb_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] dq_q, rsp_q, rd_mask;
  logic              ph_done, row_done, pre_done, idle_done, hit;
  logic              open_ok, page_ok, fire, close_now, acc_end;
  logic [CNT_W-1:0]  ph_val;

  // Handshake and page decisions
  assign open_ok   = (ph_q == PH_CLOSED) && pre_done && !supply_low;
  assign page_ok   = (ph_q == PH_OPEN) && hit && !supply_low;
  assign req_ready = open_ok || page_ok;
  assign fire      = req_valid && req_ready;
  assign acc_end   = (ph_q == PH_ACCESS) && ph_done;
  assign close_now = (ph_q == PH_OPEN) && row_done && !fire &&
                     (supply_low || idle_done || req_valid);
  assign ph_val    = open_ok ? CNT_W'(ACC_CYC) : CNT_W'(PAGE_CYC);

  nvpc_timer #(.W(CNT_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .load(fire), .load_val(ph_val), .done(ph_done));
  nvpc_timer #(.W(CNT_W)) u_rowcyc (
    .clk(clk), .rst_n(rst_n), .load(fire && open_ok), .load_val(CNT_W'(CYC_CYC)), .done(row_done));
  nvpc_timer #(.W(CNT_W)) u_prechg (
    .clk(clk), .rst_n(rst_n), .load(close_now), .load_val(CNT_W'(PRE_CYC)), .done(pre_done));
  nvpc_timer #(.W(CNT_W)) u_idle (
    .clk(clk), .rst_n(rst_n), .load(acc_end), .load_val(CNT_W'(IDLE_CYCLES)), .done(idle_done));

  nvpc_page_track #(.ROW_W(ROW_W)) u_page (
    .clk(clk), .rst_n(rst_n), .open_en(fire && open_ok), .close_en(close_now),
    .row_in(req_addr[ADDR_W-1:COL_W]), .hit(hit));

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign rd_mask[i*8 +: 8] = {8{strb_q[i]}};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q    <= PH_CLOSED;
      ce_q    <= 1'b0;
      we_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      dq_oe_q <= 1'b0;
      rd_q    <= 1'b0;
      rsp_v_q <= 1'b0;
      strb_q  <= '0;
      addr_q  <= '0;
      dq_q    <= '0;
      rsp_q   <= '0;
    end else begin
      rsp_v_q <= 1'b0;
      if (fire) begin
        ph_q    <= PH_ACCESS;
        ce_q    <= 1'b1;
        addr_q  <= req_addr;
        we_n_q  <= !req_write;
        oe_n_q  <= req_write;
        rd_q    <= !req_write;
        dq_q    <= req_wdata;
        dq_oe_q <= req_write;
        strb_q  <= LANES'(req_be);
      end else if (acc_end) begin
        ph_q   <= PH_OPEN;
        we_n_q <= 1'b1;
        oe_n_q <= 1'b1;
        if (rd_q) begin
          rsp_v_q <= 1'b1;
          rsp_q   <= mem_dq_i & rd_mask;
        end
      end else if (close_now) begin
        ph_q    <= PH_CLOSED;
        ce_q    <= 1'b0;
        dq_oe_q <= 1'b0;
      end
    end
  end

  assign mem_ce1_n = !ce_q;
  assign mem_ce2   = ce_q;
  assign mem_we_n  = we_n_q;
  assign mem_oe_n  = oe_n_q;
  assign mem_lb_n  = !strb_q[0];
  assign mem_ub_n  = !strb_q[LANES-1];
  assign mem_addr  = addr_q;
  assign mem_dq_o  = dq_q;
  assign mem_dq_oe = dq_oe_q;
  assign rsp_valid = rsp_v_q;
  assign rsp_rdata = rsp_q;
endmodule

// File: rtl/nvpc_checker.sv
module nvpc_checker #(
  parameter int ADDR_W         = 19,
  parameter int COL_W          = 2,
  parameter int CLK_PERIOD_PS  = 4000,
  parameter int T_PRECHARGE_NS = 50
) (
  input logic              clk,
  input logic              rst_n,
  input logic              supply_low,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              mem_ce1_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic [ADDR_W-1:0] mem_addr
);
  localparam int unsigned PRE_CYC = nvpc_pkg::ns_to_cycles(T_PRECHARGE_NS, CLK_PERIOD_PS);

  logic [15:0] hi_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)                          hi_cnt <= 16'hFFFF;
    else if (!mem_ce1_n)                 hi_cnt <= '0;
    else if (hi_cnt != 16'hFFFF)         hi_cnt <= hi_cnt + 1'b1;
  end

  assert_ready_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    supply_low |-> !req_ready);
  assert_no_enable_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ce1_n) |-> !$past(supply_low));
  assert_row_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce1_n && !$past(mem_ce1_n)) |-> mem_addr[ADDR_W-1:COL_W] == $past(mem_addr[ADDR_W-1:COL_W]));
  assert_we_inside_ce_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ce1_n);
  assert_we_oe_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);
  assert_rsp_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  assert_precharge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ce1_n) |-> hi_cnt >= 16'(PRE_CYC));
endmodule

bind nvram_page_ctrl nvpc_checker #(
  .ADDR_W(ADDR_W), .COL_W(COL_W), .CLK_PERIOD_PS(CLK_PERIOD_PS), .T_PRECHARGE_NS(T_PRECHARGE_NS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .supply_low(supply_low), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .mem_ce1_n(mem_ce1_n), .mem_we_n(mem_we_n),
  .mem_oe_n(mem_oe_n), .mem_addr(mem_addr)
);

// File: tb/sim_nvram_page_ctrl.sv
module sim_nvram_page_ctrl;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int PER_PS = 4000;
  localparam int ACC_E  = (60 * 1000 + PER_PS - 1) / PER_PS;
  localparam int CYC_E  = (115 * 1000 + PER_PS - 1) / PER_PS;
  localparam int PRE_E  = (50 * 1000 + PER_PS - 1) / PER_PS;
  localparam int PAGE_E = (30 * 1000 + PER_PS - 1) / PER_PS;
  localparam int IDLE_E = 40;

  logic clk = 0, rst_n = 0, supply_low = 0;
  logic req_valid = 0, req_write = 0;
  logic [18:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe;
  logic [18:0] mem_addr;
  logic [15:0] mem_dq_o;
  logic [15:0] mem_dq_i = 16'hBAD0;

  always #2 clk = ~clk;

  nvram_page_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .supply_low(supply_low),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n), .mem_addr(mem_addr),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i));

  int total = 0, bad = 0;
  int cyc = 0;
  int ce_falls = 0, last_lat = -1;
  logic [15:0] marr [logic [18:0]];
  logic [15:0] rarr [logic [18:0]];
  logic [15:0] exp_q[$];
  int          tacc_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [15:0] rd_arr(input bit model, input logic [18:0] a);
    if (model) return marr.exists(a) ? marr[a] : 16'h0000;
    return rarr.exists(a) ? rarr[a] : 16'h0000;
  endfunction

  function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] d,
                                        input logic [1:0] be);
    return {be[1] ? d[15:8] : old[15:8], be[0] ? d[7:0] : old[7:0]};
  endfunction

  // Memory model: data is valid only once the address has been stable long enough.
  bit p_ce = 0, fresh = 0, p_we_n = 1;
  logic [18:0] p_addr = '0;
  int stab = 0, lo_cnt = 0, hi_cnt = 1000;
  always @(negedge clk) begin
    if (rst_n) begin
      bit ce_now;
      int old_stab, need;
      ce_now = !mem_ce1_n && mem_ce2;
      old_stab = stab;
      need = fresh ? ACC_E : PAGE_E;
      if (ce_now && !p_ce) begin
        if (hi_cnt < PRE_E) chk(0, "R6", "precharge cycles", hi_cnt, PRE_E);
        if (supply_low) chk(0, "R9", "enable while supply low", 1, 0);
        ce_falls++;
        fresh = 1; stab = 1; lo_cnt = 1;
      end else if (!ce_now && p_ce) begin
        if (lo_cnt < CYC_E) chk(0, "R7", "row cycle cycles", lo_cnt, CYC_E);
        hi_cnt = 1;
      end else if (ce_now) begin
        lo_cnt++;
        if (mem_addr != p_addr) begin
          if (mem_addr[18:2] != p_addr[18:2]) chk(0, "R5", "row moved while enabled", mem_addr, p_addr);
          fresh = 0; stab = 1;
        end else stab++;
      end else hi_cnt++;
      if (ce_now && !p_we_n && mem_we_n) begin
        if (old_stab < need) chk(0, "R4", "write hold cycles", old_stab, need);
        if (mem_dq_oe) marr[mem_addr] = merge(rd_arr(1, mem_addr), mem_dq_o, {!mem_ub_n, !mem_lb_n});
        else chk(0, "R2", "data not driven on write", 0, 1);
      end
      need = fresh ? ACC_E : PAGE_E;
      if (ce_now && !mem_oe_n && stab >= need) begin
        logic [15:0] w;
        w = rd_arr(1, mem_addr);
        mem_dq_i <= {mem_ub_n ? 8'h5A : w[15:8], mem_lb_n ? 8'h5A : w[7:0]};
      end else mem_dq_i <= 16'hBAD0;
      p_ce = ce_now; p_addr = mem_addr; p_we_n = mem_we_n;
    end
  end

  // Response monitor (R3, R11)
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) chk(0, "R3", "unexpected response", rsp_rdata, 0);
      else begin
        logic [15:0] e;
        int t;
        e = exp_q.pop_front();
        t = tacc_q.pop_front();
        last_lat = cyc - t;
        chk(rsp_rdata == e, "R3", "read data", rsp_rdata, e);
      end
    end
  end

  task automatic issue(input bit wr, input logic [18:0] a, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk); #1;
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    #0.5;
    while (!req_ready) begin @(negedge clk); #1.5; end
    @(posedge clk); #0.5;
    req_valid = 0;
    if (wr) rarr[a] = merge(rd_arr(0, a), d, be);
    else begin
      logic [15:0] w;
      w = rd_arr(0, a);
      exp_q.push_back({be[1] ? w[15:8] : 8'h00, be[0] ? w[7:0] : 8'h00});
      tacc_q.push_back(cyc);
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge clk);
    chk(exp_q.size() == 0, "R10", "responses drained", exp_q.size(), 0);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "R10", "watchdog expired", 1, 0);
    finish_run();
  end

  initial begin
    int f0;
    void'($urandom(32'h5EED1234));
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(mem_ce1_n == 1 && mem_ce2 == 0, "R1", "enables idle", {mem_ce1_n, mem_ce2}, 2'b10);
    chk(mem_we_n && mem_oe_n && mem_ub_n && mem_lb_n, "R1", "strobes high",
        {mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n}, 4'hF);
    chk(!mem_dq_oe && !rsp_valid && req_ready, "R1", "oe/valid/ready",
        {mem_dq_oe, rsp_valid, req_ready}, 3'b001);

    // R2/R8/R11: write, let page time out, first-access read latency
    issue(1, 19'h12344, 16'hC0DE, 2'b11);
    repeat (CYC_E + IDLE_E + 10) @(negedge clk);
    chk(mem_ce1_n == 1, "R8", "page closed after idle", mem_ce1_n, 1);
    issue(0, 19'h12344, 16'h0, 2'b11);
    drain();
    chk(last_lat == ACC_E, "R11", "first access latency", last_lat, ACC_E);
    f0 = ce_falls;
    issue(0, 19'h12345, 16'h0, 2'b11);
    drain();
    chk(last_lat == PAGE_E, "R11", "page access latency", last_lat, PAGE_E);
    chk(ce_falls == f0, "R5", "page hit keeps enable", ce_falls - f0, 0);

    // R2/R3 byte masks
    issue(1, 19'h00200, 16'hFFFF, 2'b11);
    issue(1, 19'h00200, 16'h1234, 2'b01);
    issue(0, 19'h00200, 16'h0, 2'b11);
    issue(0, 19'h00200, 16'h0, 2'b10);
    issue(1, 19'h00201, 16'hAB00, 2'b10);
    issue(0, 19'h00201, 16'h0, 2'b01);
    drain();

    // R5 non-sequential page burst
    f0 = ce_falls;
    issue(1, 19'h7FFFF, 16'h3333, 2'b11);
    issue(1, 19'h7FFFC, 16'h0000, 2'b11);
    issue(1, 19'h7FFFE, 16'h2222, 2'b11);
    issue(1, 19'h7FFFD, 16'h1111, 2'b11);
    issue(0, 19'h7FFFE, 16'h0, 2'b11);
    issue(0, 19'h7FFFF, 16'h0, 2'b11);
    issue(0, 19'h7FFFC, 16'h0, 2'b11);
    drain();
    chk(ce_falls - f0 == 1, "R5", "one enable for burst", ce_falls - f0, 1);

    // R6 row change
    f0 = ce_falls;
    issue(0, 19'h00004, 16'h0, 2'b11);
    drain();
    chk(ce_falls - f0 == 1, "R6", "new row reopens", ce_falls - f0, 1);

    // R9/R10 supply low with a held request
    issue(1, 19'h55550, 16'h9999, 2'b11);
    @(negedge clk); #1; supply_low = 1;
    f0 = ce_falls;
    fork
      issue(0, 19'h55550, 16'h0, 2'b11);
      begin
        repeat (CYC_E + 20) @(negedge clk);
        chk(req_ready == 0, "R9", "ready low", req_ready, 0);
        chk(mem_ce1_n == 1, "R9", "page closed", mem_ce1_n, 1);
        chk(ce_falls == f0 && exp_q.size() == 0, "R10", "request held", ce_falls - f0, 0);
        #1; supply_low = 0;
      end
    join
    drain();
    chk(ce_falls - f0 == 1, "R10", "held request served once", ce_falls - f0, 1);

    // Random traffic
    for (int n = 0; n < 300; n++) begin
      logic [16:0] rows [4];
      logic [1:0] be;
      rows = '{17'h00000, 17'h00001, 17'h1ABCD, 17'h1FFFF};
      be = 2'($urandom_range(1, 3));
      issue($urandom_range(0, 1) == 1, {rows[$urandom_range(0, 3)], 2'($urandom_range(0, 3))},
            16'($urandom), be);
      if ($urandom_range(0, 3) == 0) repeat ($urandom_range(0, 60)) @(negedge clk);
    end
    drain();
    finish_run();
  end
endmodule